// File: doc/BRIEF.md
# Grouped Three-Bit Majority Detector

This block watches a serial bit stream, one bit per accepted cycle, and cuts it into back-to-back groups of three bits. Groups never overlap: the bit after the last bit of one group is always the first bit of the next. When a group closes, the block looks at how many of its three bits were 1. If the group held two or three ones, it raises a single-cycle flag.

The block is a small controller with two pieces of state. One tracks the slot within the current group. The other keeps a count of ones seen so far, which saturates at the threshold.

A bit is accepted on a rising clock edge when `bit_vld` is high. Cycles with `bit_vld` low are ignored completely. The block accepts a bit on every cycle and never pushes back, so it has no ready output. A producer may stall for as many cycles as it likes between bits.

The flag is registered. It is high during the clock cycle that follows the edge accepting the third bit of a qualifying group.

Top module: `grp3_majority_det`

## Requirements
- R1: While `rst` is high at a rising edge, `major_out` is 0 in the following cycle. The next accepted bit after reset is the first bit of a group, with a ones count of zero.
- R2: Accepted bits form consecutive, non-overlapping groups of three. Only the edge that accepts the third bit of a group can set `major_out`.
- R3: When the edge accepting a group's third bit completes a group with two or three 1s, `major_out` is 1 for exactly the following cycle.
- R4: A group with zero or one 1s never sets `major_out`.
- R5: `major_out` is 0 in the cycle following acceptance of the first or second bit of a group.
- R6: An edge with `bit_vld` low does not advance the group slot and does not change the ones count, whatever `bit_in` carries. `major_out` is 0 in the following cycle.
- R7: The accepted bit sequence 0,1,0,1,0,1,1,1,0 yields the flag sequence 0,0,0,0,0,1,0,0,1. Each flag value appears in the cycle after its bit.
- R8: A reset in the middle of a group discards the partial group. The bits before the reset do not count toward the next group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | High when `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial data bit |
| major_out | output | 1 | One-cycle flag: the group just closed had at least two 1s |

## Verification
Two things happen on the same edge when a group's third bit is accepted. The ones count for the closing group is judged, including the incoming bit. The count is also cleared for the next group.

The bench provokes this case with every one of the eight three-bit patterns. Each pattern is followed directly by further groups, and stall cycles are placed in every combination of positions. Some stall cycles carry a 1 on `bit_in`.

The flag is judged against an arithmetic model in the bench. A stale count would give a false flag on the following group. A cleared count would lose the third bit. Either error shows up as a mismatch against the model.

// File: rtl/grp3_majority_pkg.sv
package grp3_majority_pkg;
  localparam int unsigned DEF_GROUP_LEN = 3;
  localparam int unsigned DEF_MIN_ONES  = 2;

  function automatic int unsigned width_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/grp3_slot_ctrl.sv
module grp3_slot_ctrl #(
  parameter int unsigned GROUP_LEN = 3,
  parameter int unsigned POS_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  output logic [POS_W-1:0] slot,
  output logic             closing
);
  localparam logic [POS_W-1:0] LAST_SLOT = POS_W'(GROUP_LEN - 1);

  logic [POS_W-1:0] slot_r;

  assign closing = take && (slot_r == LAST_SLOT);
  assign slot    = slot_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_r <= '0;
    end else if (take) begin
      if (slot_r == LAST_SLOT) slot_r <= '0;
      else                     slot_r <= slot_r + POS_W'(1);
    end
  end
endmodule

// File: rtl/grp3_ones_tally.sv
module grp3_ones_tally #(
  parameter int unsigned MIN_ONES = 2,
  parameter int unsigned CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             bit_in,
  input  logic             closing,
  output logic [CNT_W-1:0] ones,
  output logic             reach
);
  localparam logic [CNT_W-1:0] CAP     = CNT_W'(MIN_ONES);
  localparam logic [CNT_W-1:0] CAP_M1  = CNT_W'(MIN_ONES - 1);

  logic [CNT_W-1:0] ones_r;
  logic [CNT_W-1:0] ones_nx;

  always_comb begin
    if (ones_r == CAP) ones_nx = ones_r;
    else               ones_nx = ones_r + {{(CNT_W-1){1'b0}}, bit_in};
  end

  assign reach = (ones_r == CAP) || (bit_in && (ones_r == CAP_M1));
  assign ones  = ones_r;

  always_ff @(posedge clk) begin
    if (rst)          ones_r <= '0;
    else if (closing) ones_r <= '0;
    else if (take)    ones_r <= ones_nx;
  end
endmodule

// File: rtl/grp3_flag_reg.sv
module grp3_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic closing,
  input  logic reach,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= closing && reach;
  end
endmodule

// File: rtl/grp3_majority_det.sv
module grp3_majority_det
  import grp3_majority_pkg::*;
#(
  parameter int unsigned GROUP_LEN = DEF_GROUP_LEN,
  parameter int unsigned MIN_ONES  = DEF_MIN_ONES
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic major_out
);
  localparam int unsigned POS_W = width_for(GROUP_LEN - 1);
  localparam int unsigned CNT_W = width_for(MIN_ONES);

  logic [POS_W-1:0] slot_q;
  logic [CNT_W-1:0] ones_q;
  logic             closing;
  logic             reach;

  grp3_slot_ctrl #(.GROUP_LEN(GROUP_LEN), .POS_W(POS_W)) u_slot (
    .clk(clk), .rst(rst), .take(bit_vld), .slot(slot_q), .closing(closing)
  );

  grp3_ones_tally #(.MIN_ONES(MIN_ONES), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .take(bit_vld), .bit_in(bit_in),
    .closing(closing), .ones(ones_q), .reach(reach)
  );

  grp3_flag_reg u_flag (
    .clk(clk), .rst(rst), .closing(closing), .reach(reach), .flag(major_out)
  );
endmodule

// File: rtl/grp3_majority_chk.sv
module grp3_majority_chk #(
  parameter int unsigned GROUP_LEN = 3,
  parameter int unsigned MIN_ONES  = 2,
  parameter int unsigned POS_W     = 2,
  parameter int unsigned CNT_W     = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_vld,
  input logic             major_out,
  input logic [POS_W-1:0] slot_q,
  input logic [CNT_W-1:0] ones_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !major_out); // R1
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst) slot_q < POS_W'(GROUP_LEN)); // R2
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst) ones_q <= CNT_W'(MIN_ONES)); // R3
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) major_out |=> !major_out); // R3
  AST_FLAG_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) (!bit_vld) |=> !major_out); // R6
  AST_STALL_HOLDS_SLOT: assert property (@(posedge clk) disable iff (rst) (!bit_vld) |=> $stable(slot_q)); // R6
  AST_STALL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst) (!bit_vld) |=> $stable(ones_q)); // R6
  AST_EARLY_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst) (bit_vld && slot_q != POS_W'(GROUP_LEN - 1)) |=> !major_out); // R5
endmodule

bind grp3_majority_det grp3_majority_chk #(
  .GROUP_LEN(GROUP_LEN), .MIN_ONES(MIN_ONES), .POS_W(POS_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .major_out(major_out),
  .slot_q(slot_q), .ones_q(ones_q)
);

// File: tb/tb_grp3_majority_det.sv
`timescale 1ns/1ps
module tb_grp3_majority_det;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic major_out;

  int checks = 0;
  int errors = 0;
  int m_pos = 0;
  int m_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  grp3_majority_det dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .major_out(major_out)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: major_out=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_vld = 1'b0;
    @(posedge clk); #1;
    check(major_out, 1'b0, "R1");
    rst = 1'b0;
    m_pos = 0; m_cnt = 0;
  endtask

  // one cycle of stimulus, with the bench model giving the expected flag
  task automatic step(input logic v, input logic b, output logic exp_o);
    logic exp;
    string req;
    exp = 1'b0;
    if (!v) req = "R6";
    else if (m_pos == 2) begin
      m_cnt += int'(b);
      exp = (m_cnt >= 2);
      req = exp ? "R3" : "R4";
      m_pos = 0; m_cnt = 0;
    end else begin
      m_cnt += int'(b);
      m_pos++;
      req = "R5";
    end
    bit_vld = v; bit_in = b;
    @(posedge clk); #1;
    check(major_out, exp, req);
    exp_o = exp;
  endtask

  initial begin
    logic e;
    logic [8:0] seq;
    logic [8:0] want;
    do_reset();
    // R2: every 3-bit pattern, every stall placement, followed by a second group
    for (int pat = 0; pat < 8; pat++) begin
      for (int gap = 0; gap < 8; gap++) begin
        for (int k = 0; k < 3; k++) begin
          if (gap[k]) step(1'b0, 1'b1, e);
          step(1'b1, pat[k], e);
        end
        for (int k = 0; k < 3; k++) step(1'b1, pat[2-k] ^ gap[k], e);
      end
    end
    // R7: stated sequence 010101110 -> 000001001
    do_reset();
    seq  = 9'b011101010; // bit i sent i-th
    want = 9'b100100000;
    for (int i = 0; i < 9; i++) begin
      step(1'b1, seq[i], e);
      checks++;
      if (major_out !== want[i]) begin
        errors++;
        $display("FAIL R7: index %0d major_out=%0b expected %0b", i, major_out, want[i]);
      end
    end
    // R8: partial group 1,1 then reset then 0,0,1 must not flag
    step(1'b1, 1'b1, e);
    step(1'b1, 1'b1, e);
    do_reset();
    step(1'b1, 1'b0, e);
    step(1'b1, 1'b0, e);
    bit_vld = 1'b1; bit_in = 1'b1;
    @(posedge clk); #1;
    check(major_out, 1'b0, "R8");
    m_pos = 0; m_cnt = 0;
    // R2: after that group the next group starts fresh
    step(1'b1, 1'b1, e);
    step(1'b1, 1'b1, e);
    step(1'b1, 1'b0, e);
    bit_vld = 1'b0;
    @(posedge clk); #1;
    check(major_out, 1'b0, "R6");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule